// File: doc/BRIEF.md
# Multi-Mode Event Counter with Dual Capture

This block holds a bank of counter channels. Each channel has a 32-bit up/down count and two 32-bit capture registers, called latch A and latch B. A channel counts in one of three ways, selected per channel:

- **Step/direction:** it counts rising steps on a step input, and a direction input decides whether each step adds or subtracts.
- **Quadrature:** it counts every transition of two phase-shifted encoder signals.
- **Pulse-width:** it counts ticks of an internal reference and uses both edges of a measured signal to take snapshots.

Every external pin passes through a two-flop synchronizer, and edges are found in the system clock domain. The internal reference is a clock enable that fires once every `REF_DIV` system cycles. An optional divide-by-4 is available on top of that.

Software uses a flat word-addressed register port. Through it, software configures each channel, reads the count and both captures, and writes one shared command word. The command word can clear, capture or reset the error flag of any set of channels in a single write. Each channel also has an auxiliary pin whose role depends on the mode:

- In step/direction and quadrature mode it acts as an external clear or an external capture.
- In pulse-width mode both of its edges take snapshots.

From the two snapshots, software can derive the high time, the low time and the period.

Top module: `tally_top`

## Requirements
- R1: After reset every count, latch A, latch B, error flag and configuration field reads 0, so every channel is disabled and in step/direction mode.
- R2: Channel c occupies words 4c..4c+3, laid out as follows:
  - Word 4c is configuration. Bits [1:0] select the mode: 0 step/direction, 1 quadrature, 2 pulse-width, 3 idle. Bit 2 sets the auxiliary role: 1 capture, 0 clear. Bit 3 is enable. Bit 4 selects the divide-by-4. A read returns these bits with the error flag in bit 8.
  - Word 4c+1 is the count, word 4c+2 is latch A and word 4c+3 is latch B.
  - The command word at 4·NUM_CH reads as 0.
- R3: In step/direction mode each rising edge of the step pin (in_a) adds 1 when the direction pin (in_b) is 1, and subtracts 1 when it is 0.
- R4: In quadrature mode every change of exactly one phase moves the count by one. The count rises when phase A leads phase B, that is, when the (A,B) sequence runs 00, 10, 11, 01, 00, and it falls for the reverse sequence.
- R5: In quadrature mode, a sample in which both phases change leaves the count unchanged and sets the error flag. The flag stays set until an error-clear command reaches that channel.
- R6: In step/direction and quadrature mode, a rising edge on the auxiliary pin has one of two effects, set by configuration bit 2. With the bit at 0 it zeroes the count. With the bit at 1 it copies the count into latch A and leaves the count unchanged.
- R7: In pulse-width mode the count rises by one every REF_DIV system cycles, or every 4·REF_DIV cycles with the divide-by-4 set. A rising auxiliary edge copies the count into latch A, and a falling edge copies it into latch B.
- R8: In the command word, the bits are grouped as follows:
  - Bits [NUM_CH-1:0] zero the counts.
  - Bits [2·NUM_CH-1:NUM_CH] copy the counts into latch A.
  - Bits [3·NUM_CH-1:2·NUM_CH] reset the error flags.
  - Each group has one bit per channel, and one write can act on several channels at once.
- R9: A clear in the same cycle as a count step leaves the count at 0. A capture in the same cycle as a clear stores the count from before the clear.
- R10: The count wraps modulo 2^32: one step down from 0 gives FFFFFFFF, and one step up from FFFFFFFF gives 0.
- R11: With the enable bit at 0 the count never steps, but clears and captures still act.
- R12: Rewriting the mode leaves the count and both latches unchanged.
- R13: In mode 3 no pin activity changes the count or the latches.
- R14: A pin change sampled at clock edge E0 shows up in the count after edge E2, and not before. A register write at edge E shows up after edge E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| in_a | input | NUM_CH | Step pin or phase A, one per channel |
| in_b | input | NUM_CH | Direction pin or phase B, one per channel |
| in_aux | input | NUM_CH | Auxiliary clear/capture pin, one per channel |

## Verification
Pin-driven results arrive two edges after the first sampling edge, through the synchronizer and edge detector. The bench therefore gives every pin change four cycles to settle before it reads, and one directed case probes the exact cycle after E1 and after E2. Register writes and commands take effect at the writing edge, so reads follow directly after the write task returns. Pulse-width results are checked as differences between latches over windows that are whole multiples of the tick period, so the free-running tick phase cancels out.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic [1:0] {
        MODE_STEPDIR = 2'd0,
        MODE_QUAD    = 2'd1,
        MODE_PULSE   = 2'd2,
        MODE_IDLE    = 2'd3
    } cnt_mode_e;

    // bit 4 div4, bit 3 enable, bit 2 aux role, bits 1:0 mode
    typedef struct packed {
        logic      div4;
        logic      en;
        logic      aux_latch;
        cnt_mode_e mode;
    } chan_cfg_t;

    localparam int CFG_W    = $bits(chan_cfg_t);
    localparam int ERR_BIT  = 8;
    localparam int SLOT_CFG = 0;
    localparam int SLOT_CNT = 1;
    localparam int SLOT_LA  = 2;
    localparam int SLOT_LB  = 3;

endpackage

// File: rtl/tally_sync.sv
module tally_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;

endmodule

// File: rtl/tally_refgen.sv
module tally_refgen #(
    parameter int REF_DIV = 6,
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic tick_slow
);

    localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] div;
        logic [PW-1:0] pre;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.div == DW'(REF_DIV - 1));
        if (wrap) begin
            st_d.div = '0;
            if (st_q.pre == PW'(PRE_DIV - 1)) st_d.pre = '0;
            else                             st_d.pre = st_q.pre + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick      = wrap;
    assign tick_slow = wrap && (st_q.pre == PW'(PRE_DIV - 1));

endmodule

// File: rtl/tally_chan.sv
module tally_chan
    import tally_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  chan_cfg_t        cfg_wdata,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             pin_aux,
    input  logic             ref_tick,
    input  logic             ref_tick_slow,
    input  logic             cmd_clr,
    input  logic             cmd_lat,
    input  logic             cmd_errclr,
    output chan_cfg_t        cfg,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] lat_a,
    output logic [CNT_W-1:0] lat_b,
    output logic             err
);

    typedef struct packed {
        chan_cfg_t        cfg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] la;
        logic [CNT_W-1:0] lb;
        logic             err;
    } chan_st_t;

    chan_st_t   st_d, st_q;
    logic [2:0] lvl, rise, fall;
    logic       chg_a, chg_b;
    logic       step_up, step_dn, bad_step;
    logic       aux_clr, aux_la, aux_lb;
    logic       do_clr, do_la, do_lb;
    logic       lvl_unused;

    tally_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_aux, pin_b, pin_a}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign lvl_unused = lvl[2];

    // step decode per mode
    always_comb begin
        step_up  = 1'b0;
        step_dn  = 1'b0;
        bad_step = 1'b0;
        chg_a    = rise[0] | fall[0];
        chg_b    = rise[1] | fall[1];
        case (st_q.cfg.mode)
            MODE_STEPDIR: begin
                step_up = rise[0] & lvl[1];
                step_dn = rise[0] & ~lvl[1];
            end
            MODE_QUAD: begin
                if (chg_a && chg_b) begin
                    bad_step = 1'b1;
                end else if (chg_a) begin
                    step_up = (lvl[0] != lvl[1]);
                    step_dn = (lvl[0] == lvl[1]);
                end else if (chg_b) begin
                    step_up = (lvl[1] == lvl[0]);
                    step_dn = (lvl[1] != lvl[0]);
                end
            end
            MODE_PULSE: begin
                step_up = st_q.cfg.div4 ? ref_tick_slow : ref_tick;
            end
            default: ;
        endcase
        if (!st_q.cfg.en) begin
            step_up  = 1'b0;
            step_dn  = 1'b0;
            bad_step = 1'b0;
        end
    end

    // auxiliary pin role per mode
    always_comb begin
        aux_clr = 1'b0;
        aux_la  = 1'b0;
        aux_lb  = 1'b0;
        case (st_q.cfg.mode)
            MODE_STEPDIR, MODE_QUAD: begin
                aux_clr = rise[2] & ~st_q.cfg.aux_latch;
                aux_la  = rise[2] & st_q.cfg.aux_latch;
            end
            MODE_PULSE: begin
                aux_la = rise[2];
                aux_lb = fall[2];
            end
            default: ;
        endcase
    end

    assign do_clr = cmd_clr | aux_clr;
    assign do_la  = cmd_lat | aux_la;
    assign do_lb  = aux_lb;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = cfg_wdata;
        if (do_la) st_d.la = st_q.cnt;
        if (do_lb) st_d.lb = st_q.cnt;
        if (do_clr)       st_d.cnt = '0;
        else if (step_up) st_d.cnt = st_q.cnt + 1'b1;
        else if (step_dn) st_d.cnt = st_q.cnt - 1'b1;
        if (cmd_errclr) st_d.err = 1'b0;
        if (bad_step)   st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg   = st_q.cfg;
    assign count = st_q.cnt;
    assign lat_a = st_q.la;
    assign lat_b = st_q.lb;
    assign err   = st_q.err;

endmodule

// File: rtl/tally_top.sv
module tally_top
    import tally_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int CNT_W   = 32,
    parameter int REF_DIV = 6,
    parameter int ADDR_W  = $clog2(4 * NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] in_a,
    input  logic [NUM_CH-1:0] in_b,
    input  logic [NUM_CH-1:0] in_aux
);

    localparam int SEL_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(4 * NUM_CH);

    logic                         ref_tick, ref_tick_slow;
    logic                         cmd_hit;
    logic [NUM_CH-1:0]            cmd_clr, cmd_lat, cmd_errclr;
    logic [NUM_CH-1:0]            cfg_we;
    chan_cfg_t                    cfg_w [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, lat_a_w, lat_b_w;
    logic [NUM_CH-1:0]            err_w, en_w;
    logic [SEL_W-1:0]             sel;
    logic [1:0]                   slot;
    logic                         wdata_unused;

    assign wdata_unused = ^reg_wdata;

    tally_refgen #(.REF_DIV(REF_DIV), .PRE_DIV(4)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ref_tick),
        .tick_slow(ref_tick_slow)
    );

    assign cmd_hit    = reg_we && (reg_addr == CMD_ADDR);
    assign cmd_clr    = cmd_hit ? reg_wdata[NUM_CH-1:0]          : '0;
    assign cmd_lat    = cmd_hit ? reg_wdata[2*NUM_CH-1:NUM_CH]   : '0;
    assign cmd_errclr = cmd_hit ? reg_wdata[3*NUM_CH-1:2*NUM_CH] : '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * i);

        assign cfg_we[i] = reg_we && (reg_addr == BASE);
        assign en_w[i]   = cfg_w[i].en;

        tally_chan #(.CNT_W(CNT_W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_we       (cfg_we[i]),
            .cfg_wdata    (chan_cfg_t'(reg_wdata[CFG_W-1:0])),
            .pin_a        (in_a[i]),
            .pin_b        (in_b[i]),
            .pin_aux      (in_aux[i]),
            .ref_tick     (ref_tick),
            .ref_tick_slow(ref_tick_slow),
            .cmd_clr      (cmd_clr[i]),
            .cmd_lat      (cmd_lat[i]),
            .cmd_errclr   (cmd_errclr[i]),
            .cfg          (cfg_w[i]),
            .count        (cnt_w[i]),
            .lat_a        (lat_a_w[i]),
            .lat_b        (lat_b_w[i]),
            .err          (err_w[i])
        );
    end

    assign sel  = reg_addr[ADDR_W-1:2];
    assign slot = reg_addr[1:0];

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == SEL_W'(i)) begin
                case (slot)
                    2'(SLOT_CFG): begin
                        reg_rdata[CFG_W-1:0] = cfg_w[i];
                        reg_rdata[ERR_BIT]   = err_w[i];
                    end
                    2'(SLOT_CNT): reg_rdata = cnt_w[i];
                    2'(SLOT_LA):  reg_rdata = lat_a_w[i];
                    default:      reg_rdata = lat_b_w[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/tally_chk.sv
module tally_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] lat_a,
    input logic [NUM_CH-1:0]            err,
    input logic [NUM_CH-1:0]            en,
    input logic [NUM_CH-1:0]            cmd_clr,
    input logic [NUM_CH-1:0]            cmd_lat,
    input logic [NUM_CH-1:0]            cmd_errclr
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R8
        clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_clr[i] |=> (cnt[i] == '0));

        // R9
        lat_preclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_lat[i] |=> (lat_a[i] == $past(cnt[i])));

        // R11
        frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !cmd_clr[i]) |=> (cnt[i] == $past(cnt[i]) || cnt[i] == '0));

        // R3
        unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1 ||
                      cnt[i] == $past(cnt[i]) - 1'b1 || cnt[i] == '0));

        // R5
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err[i] && !cmd_errclr[i]) |=> err[i]);
    end

endmodule

bind tally_top tally_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_w),
    .lat_a     (lat_a_w),
    .err       (err_w),
    .en        (en_w),
    .cmd_clr   (cmd_clr),
    .cmd_lat   (cmd_lat),
    .cmd_errclr(cmd_errclr)
);

// File: tb/sim_tally_top.sv
module sim_tally_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  in_a = '0, in_b = '0, in_aux = '0;
    int          n_run = 0, n_fail = 0;
    logic [31:0] v, va, vb;

    always #4 clk = ~clk;

    tally_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_a(in_a), .in_b(in_b), .in_aux(in_aux)
    );

    // quadrature walk on channel 1: {A, B, expected count}
    localparam logic [33:0] QVEC [10] = '{
        {2'b10, 32'd1}, {2'b11, 32'd2}, {2'b01, 32'd3}, {2'b00, 32'd4},
        {2'b01, 32'd3}, {2'b11, 32'd2}, {2'b10, 32'd1}, {2'b00, 32'd0},
        {2'b01, 32'hFFFF_FFFF}, {2'b00, 32'd0}
    };

    function automatic logic [31:0] cfgw(input int mode, input bit aux, input bit en, input bit d4);
        return {27'd0, d4, en, aux, 2'(mode)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] r);
        reg_addr = 4'(a);
        #1 r = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic step0();
        in_a[0] = 1'b1; settle();
        in_a[0] = 1'b0; settle();
    endtask

    task automatic aux0();
        in_aux[0] = 1'b1; settle();
        in_aux[0] = 1'b0; settle();
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R14 watchdog expired: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 cfg0", v, 0);
        rd(1, v); chk("R1 cnt0", v, 0);
        rd(2, v); chk("R1 latA0", v, 0);
        rd(7, v); chk("R1 latB1", v, 0);

        // R2 config readback and command word read
        wr(0, cfgw(0, 0, 1, 0));
        rd(0, v); chk("R2 cfg0 readback", v, 32'h08);
        rd(8, v); chk("R2 command reads 0", v, 0);

        // R3 step/direction
        in_b[0] = 1'b1; settle();
        repeat (3) step0();
        rd(1, v); chk("R3 up x3", v, 3);
        in_b[0] = 1'b0; settle();
        step0();
        rd(1, v); chk("R3 down", v, 2);

        // R14 pin latency
        in_b[0] = 1'b1; settle();
        in_a[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1, v); chk("R14 not after E1", v, 2);
        @(negedge clk);
        rd(1, v); chk("R14 after E2", v, 3);
        in_a[0] = 1'b0; settle();

        // R11 disabled: no counting, capture still works
        wr(0, cfgw(0, 0, 0, 0));
        step0();
        rd(1, v); chk("R11 frozen", v, 3);
        wr(8, 32'h4);
        rd(2, v); chk("R11 capture while disabled", v, 3);

        // R6 auxiliary pin roles
        wr(0, cfgw(0, 1, 1, 0));
        step0();
        aux0();
        rd(2, v); chk("R6 aux capture", v, 4);
        rd(1, v); chk("R6 capture keeps count", v, 4);
        wr(0, cfgw(0, 0, 1, 0));
        aux0();
        rd(1, v); chk("R6 aux clear", v, 0);

        // R10 wrap
        in_b[0] = 1'b0; settle();
        step0();
        rd(1, v); chk("R10 wrap down", v, 32'hFFFF_FFFF);
        in_b[0] = 1'b1; settle();
        step0();
        rd(1, v); chk("R10 wrap up", v, 0);

        // R9 clear in same cycle as step
        in_a[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h1;
        @(negedge clk);
        reg_we = 1'b0;
        in_a[0] = 1'b0; settle();
        rd(1, v); chk("R9 clear beats step", v, 0);
        step0(); step0();
        wr(8, 32'h5);
        rd(1, v); chk("R9 clear+capture count", v, 0);
        rd(2, v); chk("R9 capture pre-clear", v, 2);

        // R4 quadrature table on channel 1 (also R10)
        wr(4, cfgw(1, 0, 1, 0));
        for (int k = 0; k < 10; k++) begin
            in_a[1] = QVEC[k][33];
            in_b[1] = QVEC[k][32];
            settle();
            rd(5, v); chk($sformatf("R4 quad vec %0d", k), v, QVEC[k][31:0]);
        end

        // R5 illegal double change, sticky flag
        in_a[1] = 1'b1; in_b[1] = 1'b1; settle();
        rd(5, v); chk("R5 count held", v, 0);
        rd(4, v); chk("R5 flag set", v, 32'h109);
        in_a[1] = 1'b0; settle();
        rd(5, v); chk("R5 count after legal step", v, 1);
        rd(4, v); chk("R5 flag sticky", v, 32'h109);
        wr(8, 32'h20);
        rd(4, v); chk("R5 flag cleared", v, 32'h09);

        // R8 multi-channel clear
        step0();
        wr(8, 32'h3);
        rd(1, v); chk("R8 clear ch0", v, 0);
        rd(5, v); chk("R8 clear ch1", v, 0);

        // R12 mode change keeps state
        in_a[1] = 1'b1; settle();
        wr(8, 32'h8);
        wr(4, cfgw(0, 0, 1, 0));
        rd(5, v); chk("R12 count kept", v, 32'hFFFF_FFFF);
        rd(6, v); chk("R12 latA kept", v, 32'hFFFF_FFFF);

        // R13 idle mode
        wr(4, cfgw(3, 0, 1, 0));
        in_a[1] = 1'b0; settle();
        in_a[1] = 1'b1; settle();
        rd(5, v); chk("R13 idle count", v, 32'hFFFF_FFFF);
        rd(7, v); chk("R13 idle latB", v, 0);

        // R7 pulse width, reference every 6 cycles
        wr(0, cfgw(2, 0, 1, 0));
        in_aux[0] = 1'b1;
        repeat (60) @(negedge clk);
        in_aux[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(2, va); rd(3, vb);
        chk("R7 high time ticks", vb - va, 10);
        repeat (31) @(negedge clk);
        in_aux[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(2, va);
        chk("R7 low time ticks", va - vb, 6);

        // R7 divide-by-4
        wr(0, cfgw(2, 0, 1, 1));
        in_aux[0] = 1'b0;
        repeat (96) @(negedge clk);
        in_aux[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(2, va); rd(3, vb);
        chk("R7 div4 low ticks", va - vb, 4);

        finish_up();
    end

endmodule